// File: doc/BRIEF.md
# Write-once fuse memory controller

This block models a one-time-programmable fuse array behind a small bank of 32-bit control registers. Software programs the array one bit at a time. It writes the word index, the bit position and the data bit, then writes the write-enable register with its enable bit set. Each bit can be programmed once only. A shadow map records which bits have been programmed, and any later attempt on the same bit is refused and raises a sticky error.

A fuse word can be read through the data-out register only when the chip-enable, strobe and trim controls all have bit 0 set. In every other case data-out returns 0xFF. At reset every fuse word is all ones. A configured serial number and its bitwise complement are then preloaded into two neighbouring words. The array depth is a parameter (`WORDS`, a power of two) and defaults to a size suited to simulation.

The bus is a single request strobe with a write flag, a byte offset and a size code. Reads answer one cycle later.

Top module: `fuse_otp_ctrl`

## Requirements
- R1: After reset every control and test register reads 0 and data-out reads 0xFF. Fuse word `SERIAL_WORD` holds `SERIAL_NUM`, the next word holds its bitwise complement, every other word is 0xFFFFFFFF, and `wo_err_o` is 0.
- R2: The register map uses these byte offsets: 0x00 word index, 0x04 bit index, 0x08 data-in, 0x0C data-out, 0x10 chip enable, 0x14 strobe, 0x18 trim, 0x1C program, 0x20 write enable, 0x24 redundancy select, 0x28 fuse clock, 0x2C to 0x38 four test registers. Plain registers read back the last 32-bit value written. The word-index register keeps only its low log2(WORDS) bits, and the write-enable register keeps only bit 0.
- R3: A data-out read returns 0xFF unless bit 0 of chip enable, strobe and trim are all 1.
- R4: With those three bits set, a data-out read returns the fuse word selected by the word-index register.
- R5: A write to data-out is ignored; the fuse array and every register are unchanged.
- R6: Writing the write-enable register with bit 0 = 1 while redundancy select is zero programs the selected bit. The word comes from the word-index register, the bit from bit-index[4:0], and the new value is data-in bit 0, which may set or clear the bit. A write with bit 0 = 0 programs nothing.
- R7: While redundancy select is nonzero, a write-enable write programs nothing.
- R8: Once a bit has been programmed, any further program of that bit leaves the array unchanged and sets `wo_err_o`. That flag stays at 1 until reset.
- R9: A word-sized read of an offset that is unmapped or not word-aligned returns 0. A word-sized write there changes nothing and pulses `bad_wr_o` for one cycle in the next cycle.
- R10: An access whose size code is not 2 (4 bytes) has no effect. A read of that kind returns 0 and does not raise `bad_wr_o`.
- R11: Every read request gives `rsp_valid_o` = 1 with its data in the following cycle. Writes never raise `rsp_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Access request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_off_i | input | 8 | Byte offset of the register |
| req_size_i | input | 2 | Access size code, 2 = 32 bits |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | 32 | Read data |
| bad_wr_o | output | 1 | Pulse: word write to an unmapped offset |
| wo_err_o | output | 1 | Sticky: rejected second program of a bit |

## Verification
The hardest state to reach is a second program of a bit that was already programmed. It needs a matching word and bit index, redundancy select at zero, and an earlier successful program of that bit, and the outcome only shows up through a later gated data-out read. The random stimulus therefore draws word indices from a handful of words and bit indices from a handful of positions, so repeat programs happen often. It also toggles the three read enables and redundancy select. Directed sequences program a bit, retry it with the opposite data, and read the word back.

// File: rtl/fuse_otp_pkg.sv
package fuse_otp_pkg;
    typedef enum logic [3:0] {
        SEL_ADDR  = 4'd0,
        SEL_BIT   = 4'd1,
        SEL_DIN   = 4'd2,
        SEL_DOUT  = 4'd3,
        SEL_CE    = 4'd4,
        SEL_STB   = 4'd5,
        SEL_TRIM  = 4'd6,
        SEL_PROG  = 4'd7,
        SEL_WREN  = 4'd8,
        SEL_REDUN = 4'd9,
        SEL_FCLK  = 4'd10,
        SEL_TST0  = 4'd11,
        SEL_TST1  = 4'd12,
        SEL_TST2  = 4'd13,
        SEL_TST3  = 4'd14
    } reg_sel_e;

    localparam int          NUM_REGS  = 15;
    localparam logic [1:0]  SIZE_WORD = 2'd2;
    localparam logic [31:0] CLOSED_RD = 32'h0000_00FF;
endpackage

// File: rtl/fuse_regs.sv
module fuse_regs
    import fuse_otp_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             req_valid_i,
    input  logic             req_write_i,
    input  logic [7:0]       req_off_i,
    input  logic [1:0]       req_size_i,
    input  logic [31:0]      req_wdata_i,
    input  logic [31:0]      fuse_word_i,
    output logic [IDX_W-1:0] addr_o,
    output logic [4:0]       bit_o,
    output logic             din_bit_o,
    output logic             prog_fire_o,
    output logic             rd_open_o,
    output logic             rsp_valid_o,
    output logic [31:0]      rsp_rdata_o,
    output logic             bad_wr_o
);
    typedef struct packed {
        logic [IDX_W-1:0] addr;
        logic [31:0]      bitsel;
        logic [31:0]      din;
        logic [31:0]      ce;
        logic [31:0]      stb;
        logic [31:0]      trim;
        logic [31:0]      prog;
        logic             wren;
        logic [31:0]      redun;
        logic [31:0]      fclk;
        logic [3:0][31:0] tst;
        logic [31:0]      rdata;
        logic             rvalid;
        logic             bad_wr;
    } regs_t;

    regs_t    st_q, st_d;
    logic     word_ok, mapped, open;
    reg_sel_e sel;
    logic [31:0] rd_mux;

    always_comb begin
        word_ok = (req_size_i == SIZE_WORD);
        mapped  = (req_off_i[1:0] == 2'b00) && (req_off_i[7:2] < 6'(NUM_REGS));
        sel     = reg_sel_e'(req_off_i[5:2]);
        open    = st_q.ce[0] & st_q.stb[0] & st_q.trim[0];

        unique case (sel)
            SEL_ADDR:  rd_mux = 32'(st_q.addr);
            SEL_BIT:   rd_mux = st_q.bitsel;
            SEL_DIN:   rd_mux = st_q.din;
            SEL_DOUT:  rd_mux = open ? fuse_word_i : CLOSED_RD;
            SEL_CE:    rd_mux = st_q.ce;
            SEL_STB:   rd_mux = st_q.stb;
            SEL_TRIM:  rd_mux = st_q.trim;
            SEL_PROG:  rd_mux = st_q.prog;
            SEL_WREN:  rd_mux = {31'd0, st_q.wren};
            SEL_REDUN: rd_mux = st_q.redun;
            SEL_FCLK:  rd_mux = st_q.fclk;
            SEL_TST0:  rd_mux = st_q.tst[0];
            SEL_TST1:  rd_mux = st_q.tst[1];
            SEL_TST2:  rd_mux = st_q.tst[2];
            SEL_TST3:  rd_mux = st_q.tst[3];
            default:   rd_mux = 32'd0;
        endcase

        st_d        = st_q;
        st_d.rvalid = 1'b0;
        st_d.bad_wr = 1'b0;
        prog_fire_o = 1'b0;

        if (req_valid_i && !req_write_i) begin
            st_d.rvalid = 1'b1;
            st_d.rdata  = (word_ok && mapped) ? rd_mux : 32'd0;
        end

        if (req_valid_i && req_write_i && word_ok) begin
            if (!mapped) begin
                st_d.bad_wr = 1'b1;
            end else begin
                unique case (sel)
                    SEL_ADDR:  st_d.addr   = req_wdata_i[IDX_W-1:0];
                    SEL_BIT:   st_d.bitsel = req_wdata_i;
                    SEL_DIN:   st_d.din    = req_wdata_i;
                    SEL_DOUT:  ;
                    SEL_CE:    st_d.ce     = req_wdata_i;
                    SEL_STB:   st_d.stb    = req_wdata_i;
                    SEL_TRIM:  st_d.trim   = req_wdata_i;
                    SEL_PROG:  st_d.prog   = req_wdata_i;
                    SEL_WREN: begin
                        st_d.wren   = req_wdata_i[0];
                        prog_fire_o = req_wdata_i[0] && (st_q.redun == 32'd0);
                    end
                    SEL_REDUN: st_d.redun  = req_wdata_i;
                    SEL_FCLK:  st_d.fclk   = req_wdata_i;
                    SEL_TST0:  st_d.tst[0] = req_wdata_i;
                    SEL_TST1:  st_d.tst[1] = req_wdata_i;
                    SEL_TST2:  st_d.tst[2] = req_wdata_i;
                    SEL_TST3:  st_d.tst[3] = req_wdata_i;
                    default:   ;
                endcase
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_o      = st_q.addr;
    assign bit_o       = st_q.bitsel[4:0];
    assign din_bit_o   = st_q.din[0];
    assign rd_open_o   = open;
    assign rsp_valid_o = st_q.rvalid;
    assign rsp_rdata_o = st_q.rdata;
    assign bad_wr_o    = st_q.bad_wr;
endmodule

// File: rtl/fuse_core.sv
module fuse_core #(
    parameter int          WORDS       = 64,
    parameter int          IDX_W       = 6,
    parameter int          SERIAL_WORD = 60,
    parameter logic [31:0] SERIAL_NUM  = 32'hA5C3_0F17
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             prog_fire_i,
    input  logic [IDX_W-1:0] addr_i,
    input  logic [4:0]       bit_i,
    input  logic             din_bit_i,
    output logic [31:0]      word_o,
    output logic             wo_err_o
);
    typedef struct packed {
        logic [WORDS-1:0][31:0] fuse;
        logic [WORDS-1:0][31:0] done;
        logic                   err;
    } core_t;

    core_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (prog_fire_i) begin
            if (st_q.done[addr_i][bit_i]) begin
                st_d.err = 1'b1;
            end else begin
                st_d.fuse[addr_i][bit_i] = din_bit_i;
                st_d.done[addr_i][bit_i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int w = 0; w < WORDS; w++) begin
                if (w == SERIAL_WORD) begin
                    st_q.fuse[w] <= SERIAL_NUM;
                end else if (w == SERIAL_WORD + 1) begin
                    st_q.fuse[w] <= ~SERIAL_NUM;
                end else begin
                    st_q.fuse[w] <= '1;
                end
            end
            st_q.done <= '0;
            st_q.err  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o   = st_q.fuse[addr_i];
    assign wo_err_o = st_q.err;
endmodule

// File: rtl/fuse_otp_ctrl.sv
module fuse_otp_ctrl #(
    parameter int          WORDS       = 64,
    parameter int          SERIAL_WORD = 60,
    parameter logic [31:0] SERIAL_NUM  = 32'hA5C3_0F17
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        req_valid_i,
    input  logic        req_write_i,
    input  logic [7:0]  req_off_i,
    input  logic [1:0]  req_size_i,
    input  logic [31:0] req_wdata_i,
    output logic        rsp_valid_o,
    output logic [31:0] rsp_rdata_o,
    output logic        bad_wr_o,
    output logic        wo_err_o
);
    localparam int IDX_W = $clog2(WORDS);

    logic [IDX_W-1:0] addr;
    logic [4:0]       bitsel;
    logic             din_bit;
    logic             prog_fire;
    logic             rd_open;
    logic [31:0]      fuse_word;

    fuse_regs #(.IDX_W(IDX_W)) u_regs (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .req_valid_i (req_valid_i),
        .req_write_i (req_write_i),
        .req_off_i   (req_off_i),
        .req_size_i  (req_size_i),
        .req_wdata_i (req_wdata_i),
        .fuse_word_i (fuse_word),
        .addr_o      (addr),
        .bit_o       (bitsel),
        .din_bit_o   (din_bit),
        .prog_fire_o (prog_fire),
        .rd_open_o   (rd_open),
        .rsp_valid_o (rsp_valid_o),
        .rsp_rdata_o (rsp_rdata_o),
        .bad_wr_o    (bad_wr_o)
    );

    fuse_core #(
        .WORDS       (WORDS),
        .IDX_W       (IDX_W),
        .SERIAL_WORD (SERIAL_WORD),
        .SERIAL_NUM  (SERIAL_NUM)
    ) u_core (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .prog_fire_i (prog_fire),
        .addr_i      (addr),
        .bit_i       (bitsel),
        .din_bit_i   (din_bit),
        .word_o      (fuse_word),
        .wo_err_o    (wo_err_o)
    );
endmodule

// File: rtl/fuse_otp_chk.sv
module fuse_otp_chk (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        req_valid_i,
    input logic        req_write_i,
    input logic [7:0]  req_off_i,
    input logic [1:0]  req_size_i,
    input logic        rsp_valid_o,
    input logic [31:0] rsp_rdata_o,
    input logic        bad_wr_o,
    input logic        wo_err_o,
    input logic        rd_open
);
    logic rd_req, word_sz, unmapped;
    assign rd_req   = req_valid_i && !req_write_i;
    assign word_sz  = (req_size_i == 2'd2);
    assign unmapped = (req_off_i[1:0] != 2'b00) || (req_off_i > 8'h38);

    // R11: every read answers in the next cycle
    a_r11_read_answered: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_req |=> rsp_valid_o);
    // R11: writes never answer
    a_r11_write_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_write_i) |=> !rsp_valid_o);
    // R3: closed data-out reads 0xFF
    a_r3_dout_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_req && word_sz && req_off_i == 8'h0C && !rd_open) |=> (rsp_rdata_o == 32'hFF));
    // R9: unmapped word read returns zero
    a_r9_unmapped_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_req && word_sz && unmapped) |=> (rsp_rdata_o == 32'd0));
    // R9: unmapped word write flags bad_wr_o
    a_r9_bad_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_write_i && word_sz && unmapped) |=> bad_wr_o);
    // R9: no flag without an unmapped word write
    a_r9_no_false_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(req_valid_i && req_write_i && word_sz && unmapped) |=> !bad_wr_o);
    // R10: odd-size read returns zero
    a_r10_size_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_req && !word_sz) |=> (rsp_rdata_o == 32'd0));
    // R8: error flag is sticky
    a_r8_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wo_err_o |=> wo_err_o);
endmodule

bind fuse_otp_ctrl fuse_otp_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .req_off_i   (req_off_i),
    .req_size_i  (req_size_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_rdata_o (rsp_rdata_o),
    .bad_wr_o    (bad_wr_o),
    .wo_err_o    (wo_err_o),
    .rd_open     (rd_open)
);

// File: tb/fuse_otp_ctrl_tb_top.sv
module fuse_otp_ctrl_tb_top;
    localparam int          CLK_PERIOD = 10;
    localparam int          WORDS      = 64;
    localparam int          SER_W      = 60;
    localparam logic [31:0] SER_NUM    = 32'hA5C3_0F17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [7:0]  req_off = '0;
    logic [1:0]  req_size = 2'd2;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, bad_wr, wo_err;
    logic [31:0] rsp_rdata;

    int errors = 0, checks = 0;
    bit finished = 1'b0;

    logic [31:0] m_fuse [WORDS];
    logic [31:0] m_done [WORDS];
    logic [31:0] m_reg  [15];
    bit          m_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    fuse_otp_ctrl #(.WORDS(WORDS), .SERIAL_WORD(SER_W), .SERIAL_NUM(SER_NUM)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
        .req_off_i(req_off), .req_size_i(req_size), .req_wdata_i(req_wdata),
        .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .bad_wr_o(bad_wr), .wo_err_o(wo_err)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic bit is_mapped(input logic [7:0] off);
        return (off[1:0] == 2'b00) && (off <= 8'h38);
    endfunction

    function automatic logic [31:0] model_read(input logic [7:0] off);
        int idx = int'(off[7:2]);
        if (idx == 3) begin
            if (m_reg[4][0] && m_reg[5][0] && m_reg[6][0]) return m_fuse[m_reg[0]];
            return 32'hFF;
        end
        return m_reg[idx];
    endfunction

    task automatic model_write(input logic [7:0] off, input logic [31:0] d);
        int idx = int'(off[7:2]);
        int a, b;
        case (idx)
            0: m_reg[0] = d & (WORDS - 1);
            3: ;
            8: begin
                m_reg[8] = {31'd0, d[0]};
                if (d[0] && m_reg[9] == 32'd0) begin
                    a = int'(m_reg[0]);
                    b = int'(m_reg[1][4:0]);
                    if (m_done[a][b]) m_err = 1'b1;
                    else begin
                        m_fuse[a][b] = m_reg[2][0];
                        m_done[a][b] = 1'b1;
                    end
                end
            end
            default: m_reg[idx] = d;
        endcase
    endtask

    // One access: drive at a falling edge, sample at the next falling edge.
    task automatic acc(input bit wr, input logic [7:0] off, input logic [31:0] d,
                       input logic [1:0] sz);
        logic [31:0] exp_rd;
        bit exp_bw;
        string tag;
        exp_rd = (sz == 2'd2 && is_mapped(off)) ? model_read(off) : 32'd0;
        exp_bw = wr && sz == 2'd2 && !is_mapped(off);
        if (sz != 2'd2) tag = "R10";
        else if (!is_mapped(off)) tag = "R9";
        else if (off == 8'h0C) tag = "R3/R4";
        else tag = "R2";
        req_valid = 1'b1; req_write = wr; req_off = off; req_wdata = d; req_size = sz;
        @(negedge clk);
        req_valid = 1'b0;
        if (wr && sz == 2'd2 && is_mapped(off)) model_write(off, d);
        if (!wr) begin
            chk("R11 rsp_valid", {31'd0, rsp_valid}, 32'd1);
            chk(tag, rsp_rdata, exp_rd);
        end else begin
            chk("R11 no rsp on write", {31'd0, rsp_valid}, 32'd0);
            chk("R9 bad_wr", {31'd0, bad_wr}, {31'd0, exp_bw});
        end
        chk("R8 wo_err", {31'd0, wo_err}, {31'd0, m_err});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int w = 0; w < WORDS; w++) begin
            m_fuse[w] = (w == SER_W) ? SER_NUM : (w == SER_W + 1) ? ~SER_NUM : 32'hFFFF_FFFF;
            m_done[w] = '0;
        end
        for (int r = 0; r < 15; r++) m_reg[r] = '0;
        m_err = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values of all registers, data-out closed
        for (int r = 0; r < 15; r++) acc(1'b0, 8'(r * 4), 32'd0, 2'd2);
        // R1: preloaded serial words and a plain word
        acc(1'b1, 8'h10, 32'd1, 2'd2);
        acc(1'b1, 8'h14, 32'd1, 2'd2);
        acc(1'b1, 8'h18, 32'd1, 2'd2);
        acc(1'b1, 8'h00, 32'(SER_W), 2'd2);
        acc(1'b0, 8'h0C, 32'd0, 2'd2);
        chk("R1 serial", m_fuse[SER_W], SER_NUM);
        acc(1'b1, 8'h00, 32'(SER_W + 1), 2'd2);
        acc(1'b0, 8'h0C, 32'd0, 2'd2);
        acc(1'b1, 8'h00, 32'd0, 2'd2);
        acc(1'b0, 8'h0C, 32'd0, 2'd2);

        // R2: word index masking
        acc(1'b1, 8'h00, 32'hFFFF_FF45, 2'd2);
        acc(1'b0, 8'h00, 32'd0, 2'd2);
        // R6: clear bit 3 of word 5, then read back
        acc(1'b1, 8'h00, 32'd5, 2'd2);
        acc(1'b1, 8'h04, 32'd3, 2'd2);
        acc(1'b1, 8'h08, 32'd0, 2'd2);
        acc(1'b1, 8'h20, 32'd1, 2'd2);
        acc(1'b0, 8'h0C, 32'd0, 2'd2);
        chk("R6 bit cleared", m_fuse[5], 32'hFFFF_FFF7);
        // R8: second program with opposite data is refused
        acc(1'b1, 8'h08, 32'd1, 2'd2);
        acc(1'b1, 8'h20, 32'd1, 2'd2);
        acc(1'b0, 8'h0C, 32'd0, 2'd2);
        chk("R8 err set", {31'd0, wo_err}, 32'd1);
        // R5: write to data-out is ignored
        acc(1'b1, 8'h0C, 32'h0, 2'd2);
        acc(1'b0, 8'h0C, 32'd0, 2'd2);
        // R7: redundancy select blocks programming
        acc(1'b1, 8'h24, 32'd1, 2'd2);
        acc(1'b1, 8'h04, 32'd9, 2'd2);
        acc(1'b1, 8'h08, 32'd0, 2'd2);
        acc(1'b1, 8'h20, 32'd1, 2'd2);
        acc(1'b0, 8'h0C, 32'd0, 2'd2);
        acc(1'b1, 8'h24, 32'd0, 2'd2);
        // R9, R10
        acc(1'b1, 8'h3C, 32'h1234, 2'd2);
        acc(1'b0, 8'h41, 32'd0, 2'd2);
        acc(1'b1, 8'h2C, 32'hDEAD, 2'd1);
        acc(1'b0, 8'h2C, 32'd0, 2'd0);
        acc(1'b0, 8'h2C, 32'd0, 2'd2);

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            int k = int'($urandom_range(0, 99));
            logic [7:0]  off;
            logic [31:0] d = $urandom;
            logic [1:0]  sz = 2'd2;
            bit wr = 1'b1;
            if (k < 12) begin off = 8'h00; d = {d[31:8], 5'd0, d[2:0] + 3'd56}; end
            else if (k < 22) begin off = 8'h04; d[4:0] = 5'(d[1:0]); end
            else if (k < 30) off = 8'h08;
            else if (k < 40) begin off = 8'(8'h10 + 8'(4 * $urandom_range(0, 2))); d[0] = (d[3:1] != 3'd0); end
            else if (k < 45) begin off = 8'h24; d = (d[3:0] == 4'd0) ? d : 32'd0; end
            else if (k < 58) off = 8'h20;
            else if (k < 62) off = 8'(4 * $urandom_range(0, 14));
            else if (k < 88) begin off = (k < 78) ? 8'h0C : 8'(4 * $urandom_range(0, 14)); wr = 1'b0; end
            else if (k < 94) begin off = 8'($urandom_range(8'h39, 8'hFF)); wr = k[0]; end
            else begin off = 8'(4 * $urandom_range(0, 14)); sz = 2'($urandom_range(0, 1)) + (k[0] ? 2'd3 : 2'd0); wr = k[1]; end
            acc(wr, off, d, sz);
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule